// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Logic Unit with Zero Detect

This block is the combinational datapath unit of a small single-cycle processor. It takes two 16-bit operands and a 3-bit operation select, and it returns a 16-bit result together with a flag that is high when that result is all zeros. The instruction decoder drives the select from the low three bits of the register-type opcode, with no translation in between. Branch logic uses the zero flag after a subtract to decide whether two registers are equal.

There are eight operations: four bitwise functions, wrapping add and subtract, a signed less-than compare that returns 1 or 0, and a logical left shift for the shift-immediate instruction. The block holds no state. Every output follows its inputs within the same cycle. It produces no carry or overflow indication.

Top module: `alu16_core`

## Requirements
- R1: Select 3'b000 returns A AND B, 3'b001 returns A OR B, and 3'b011 returns A XOR B, bit for bit.
- R2: `zero_o` is 1 exactly when all 16 bits of `result_o` are 0, for every select code.
- R3: Select 3'b010 returns the bitwise complement of A, and operand B has no effect on the result.
- R4: Select 3'b100 returns A minus B modulo 2^16, so 0 minus 1 gives 16'hFFFF.
- R5: Select 3'b101 returns A plus B modulo 2^16, so 16'hFFFF plus 1 gives 16'h0000 and raises `zero_o`.
- R6: Select 3'b110 treats A and B as two's-complement signed values. It returns 16'h0001 when A is less than B and 16'h0000 otherwise, including when A equals B.
- R7: Select 3'b111 returns A shifted left by B[3:0] places, with zeros entering at the low end. B[15:4] has no effect on the result.
- R8: The outputs depend only on the current inputs. A new input set is reflected on `result_o` and `zero_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand, or the shift amount in bits [3:0] |
| op_i | input | 3 | Operation select |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bitwise operations are tried with complementary and overlapping bit patterns. This shows up any select code that has been swapped for another. The arithmetic operations are tried at the wrap points, such as 0 minus 1 and all-ones plus 1. The signed compare is tried across the sign boundary: 16'h8000 against 16'h7FFF, -1 against 1, and equal operands. These cases separate a signed compare from an unsigned one and from a less-or-equal compare. The shift is tried with amounts of 0 and 15, and with upper B bits set, to show that only the low four bits act. A pseudo-random sweep over all eight codes then catches mix-ups between the operations and errors in the zero flag.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   typedef enum logic [2:0] {
      OP_AND = 3'b000,
      OP_OR  = 3'b001,
      OP_NOT = 3'b010,
      OP_XOR = 3'b011,
      OP_SUB = 3'b100,
      OP_ADD = 3'b101,
      OP_SLT = 3'b110,
      OP_SHL = 3'b111
   } alu_op_e;
endpackage

// File: rtl/alu16_bitwise.sv
module alu16_bitwise #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] not_o,
   output logic [WIDTH-1:0] xor_o
);
   // one gate column per bit; the four functions share nothing
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_o[i] = a_i[i] & b_i[i];
      assign or_o[i]  = a_i[i] | b_i[i];
      assign not_o[i] = ~a_i[i];
      assign xor_o[i] = a_i[i] ^ b_i[i];
   end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] diff_o,
   output logic [WIDTH-1:0] lt_o
);
   localparam int MSB = WIDTH - 1;

   logic ovf;
   logic lt;

   assign sum_o  = a_i + b_i;
   assign diff_o = a_i - b_i;

   // signed less-than from the shared subtractor: sign of the difference,
   // corrected when the subtraction overflowed
   assign ovf = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ diff_o[MSB]);
   assign lt  = diff_o[MSB] ^ ovf;

   assign lt_o = {{(WIDTH-1){1'b0}}, lt};
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
   parameter int WIDTH   = 16,
   parameter bit BARREL  = 1'b1,
   localparam int SHW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [SHW-1:0]   amt_i,
   output logic [WIDTH-1:0] shl_o
);
   if (BARREL) begin : g_barrel
      logic [WIDTH-1:0] stage [SHW+1];
      assign stage[0] = a_i;
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
      end
      assign shl_o = stage[SHW];
   end else begin : g_operator
      assign shl_o = a_i << amt_i;
   end
endmodule

// File: rtl/alu16_zero_detect.sv
module alu16_zero_detect #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] value_i,
   output logic             zero_o
);
   logic [WIDTH-1:0] any_set;

   // ripple OR chain written per bit; synthesis rebalances it into a tree
   assign any_set[0] = value_i[0];
   for (genvar i = 1; i < WIDTH; i++) begin : g_or
      assign any_set[i] = any_set[i-1] | value_i[i];
   end
   assign zero_o = ~any_set[WIDTH-1];
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
   parameter int WIDTH          = 16,
   parameter int OP_W           = 3,
   parameter bit BARREL_SHIFTER = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o
);
   import alu16_pkg::*;

   localparam int SHW = $clog2(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu16_core: WIDTH must be at least 2");
   end
   if (OP_W != 3) begin : g_bad_op
      $error("alu16_core: OP_W must be 3 to match the opcode low bits");
   end
   if ((1 << SHW) != WIDTH) begin : g_bad_pow2
      $error("alu16_core: WIDTH must be a power of two");
   end

   logic [WIDTH-1:0] and_r, or_r, not_r, xor_r;
   logic [WIDTH-1:0] sum_r, diff_r, lt_r, shl_r;
   alu_op_e          op;

   assign op = alu_op_e'(op_i);

   alu16_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a_i   (a_i),
      .b_i   (b_i),
      .and_o (and_r),
      .or_o  (or_r),
      .not_o (not_r),
      .xor_o (xor_r)
   );

   alu16_arith #(.WIDTH(WIDTH)) u_arith (
      .a_i    (a_i),
      .b_i    (b_i),
      .sum_o  (sum_r),
      .diff_o (diff_r),
      .lt_o   (lt_r)
   );

   alu16_shifter #(.WIDTH(WIDTH), .BARREL(BARREL_SHIFTER)) u_shifter (
      .a_i   (a_i),
      .amt_i (b_i[SHW-1:0]),
      .shl_o (shl_r)
   );

   always_comb begin
      unique case (op)
         OP_AND:  result_o = and_r;
         OP_OR:   result_o = or_r;
         OP_NOT:  result_o = not_r;
         OP_XOR:  result_o = xor_r;
         OP_SUB:  result_o = diff_r;
         OP_ADD:  result_o = sum_r;
         OP_SLT:  result_o = lt_r;
         OP_SHL:  result_o = shl_r;
         default: result_o = '0;
      endcase
   end

   alu16_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .value_i (result_o),
      .zero_o  (zero_o)
   );
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
   parameter int WIDTH = 16,
   parameter int OP_W  = 3,
   localparam int SHW  = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [OP_W-1:0]  op_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o
);
   logic [WIDTH-1:0] low_mask;
   assign low_mask = (WIDTH'(1) << b_i[SHW-1:0]) - WIDTH'(1);

   always_comb begin
      // R2: flag from the detector agrees with the selected result
      p_zero_flag_r2: assert (zero_o == (result_o == '0));
      // R1: OR result covers every set bit of both operands
      if (op_i == 3'b001)
         p_or_covers_r1: assert (((result_o & a_i) == a_i) && ((result_o & b_i) == b_i));
      // R3: complement never shares a set bit with A
      if (op_i == 3'b010)
         p_not_disjoint_r3: assert ((result_o & a_i) == '0);
      // R6: compare result is 0 or 1
      if (op_i == 3'b110)
         p_slt_binary_r6: assert (result_o[WIDTH-1:1] == '0);
      // R7: bits below the shift amount are zero-filled
      if (op_i == 3'b111)
         p_shl_zero_fill_r7: assert ((result_o & low_mask) == '0);
   end
endmodule

bind alu16_core alu16_checker #(.WIDTH(WIDTH), .OP_W(OP_W)) u_checker (
   .a_i      (a_i),
   .b_i      (b_i),
   .op_i     (op_i),
   .result_o (result_o),
   .zero_o   (zero_o)
);

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic [2:0]   op;
   logic [W-1:0] res;
   logic         zf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [W-1:0] exp_res;
      logic         exp_zf;
      string        tag;
   } item_t;

   item_t sb[$];

   always #2.5 clk = ~clk;

   alu16_core dut_i (
      .a_i      (a),
      .b_i      (b),
      .op_i     (op),
      .result_o (res),
      .zero_o   (zf)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [2:0] o);
      case (o)
         3'b000:  return x & y;
         3'b001:  return x | y;
         3'b010:  return ~x;
         3'b011:  return x ^ y;
         3'b100:  return x - y;
         3'b101:  return x + y;
         3'b110:  return ($signed(x) < $signed(y)) ? 16'h0001 : 16'h0000;
         default: return x << y[3:0];
      endcase
   endfunction

   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [2:0] o, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      a = x; b = y; op = o;
      it.exp_res = model(x, y, o);
      it.exp_zf  = (it.exp_res == '0);
      it.tag     = tag;
      sb.push_back(it);
   endtask

   // monitor: combinational outputs are settled by the falling edge
   always @(negedge clk) begin
      if (!rst && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (res !== it.exp_res || zf !== it.exp_zf) begin
            fails++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     it.tag, res, zf, it.exp_res, it.exp_zf);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] lfsr;
      a = '0; b = '0; op = 3'b000;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // initial state: all-zero inputs give zero result, flag high (R2)
      drive(16'h0000, 16'h0000, 3'b000, "R2 idle");
      // R1 bitwise
      drive(16'hF0F0, 16'hFF00, 3'b000, "R1 and");
      drive(16'hF0F0, 16'h0F0F, 3'b000, "R1 and disjoint R2");
      drive(16'hF0F0, 16'h0F0F, 3'b001, "R1 or");
      drive(16'hAAAA, 16'hFFFF, 3'b011, "R1 xor");
      drive(16'h5A5A, 16'h5A5A, 3'b011, "R1 xor self R2");
      // R3 complement, B varied
      drive(16'h1234, 16'h0000, 3'b010, "R3 not b0");
      drive(16'h1234, 16'hFFFF, 3'b010, "R3 not bF");
      drive(16'hFFFF, 16'h5555, 3'b010, "R3 not to zero R2");
      // R4 subtract
      drive(16'h0000, 16'h0001, 3'b100, "R4 sub wrap");
      drive(16'h1234, 16'h1234, 3'b100, "R4 sub equal R2");
      drive(16'h8000, 16'h0001, 3'b100, "R4 sub");
      // R5 add
      drive(16'hFFFF, 16'h0001, 3'b101, "R5 add wrap R2");
      drive(16'h7FFF, 16'h0001, 3'b101, "R5 add");
      // R6 signed compare
      drive(16'hFFFF, 16'h0001, 3'b110, "R6 -1<1");
      drive(16'h0001, 16'hFFFF, 3'b110, "R6 1<-1");
      drive(16'h8000, 16'h7FFF, 3'b110, "R6 min<max");
      drive(16'h7FFF, 16'h8000, 3'b110, "R6 max<min");
      drive(16'h0042, 16'h0042, 3'b110, "R6 equal");
      // R7 shift
      drive(16'h00F1, 16'h0000, 3'b111, "R7 shl 0");
      drive(16'h0003, 16'h000F, 3'b111, "R7 shl 15");
      drive(16'h0101, 16'hFFF3, 3'b111, "R7 shl upper b ignored");
      drive(16'h8000, 16'h0001, 3'b111, "R7 shl out R2");
      // R8 sweep: every vector checked in the cycle it is applied
      lfsr = 16'hACE1;
      for (int i = 0; i < 240; i++) begin
         logic [W-1:0] x;
         x = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(x, lfsr, 3'(i), "R8 sweep");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule